// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block is a calendar clock. It holds seconds, minutes, hours, weekday, date, month and a two-digit year, and each time field is a packed BCD byte with the tens digit in the upper nibble and the units digit in the lower one. A single-cycle tick at one pulse per second advances the clock. Carries run through the whole calendar, including month lengths and leap years.

A host reaches the block over a byte-wide register port made of an address, a write strobe, write data and a registered read data bus. The eight registers sit at the top eight byte addresses of a 2^ADDR_W byte window.

Writes that carry an out-of-range value for a time field are dropped without notice. A stop flag held in the seconds register freezes the count. A control byte keeps certain bits at fixed values.

Top module: `bcd_rtc_bank`

## Requirements
- R1: The registers sit at window offsets 0x1FF8 to 0x1FFF (the default ADDR_W is 13), in this order: 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday/century, 5 date, 6 month, 7 year. Every time field is packed BCD.
- R2: A seconds write takes its value from bits 6:0 and is accepted only when both digits are decimal and the value is 0 to 59. Bit 7 always loads the stop flag, even when the value is rejected. A seconds read returns {stop, seconds[6:0]}.
- R3: A control write stores the written byte with bit 5 cleared and bits 7 and 4 set. A control read returns the stored byte.
- R4: While the stop flag is 1, ticks do not change any time field. After the flag is cleared, counting resumes from the frozen value.
- R5: A minutes write uses bits 6:0 and is accepted for 0 to 59. An hours write uses bits 5:0 and is accepted for 0 to 23. Both fields must have decimal digits.
- R6: A write to register 4 always stores bits 2:0 as the weekday and bit 6 as the century flag. A read of register 4 returns the weekday ORed with (flag << 6).
- R7: A date write uses bits 5:0 and is accepted for 1 to 31. A month write uses bits 4:0 and is accepted for 1 to 12. A year write uses all 8 bits and is accepted for 0 to 99. All three fields must have decimal digits.
- R8: Each tick while the clock is running advances the seconds. Seconds wrap 59 to 00 into minutes, minutes wrap 59 to 00 into hours, and hours wrap 23 to 00 into the next day. The next day advances the weekday, which goes from 7 to 1 and otherwise adds one.
- R9: A new day moves the date to 01 and advances the month once the date has reached the month length: 28, or 29 when the year is divisible by 4, for February; 30 for April, June, September and November; 31 otherwise. Month 12 goes to 1 and advances the year, and year 99 goes to 00.
- R10: An accepted field write in the same cycle as a tick stores the written value. The tick still updates the other fields, with carries taken from the values held before the write.
- R11: Reset clears the stop flag and the century flag. It loads 00:00:00, weekday 1, date 01, month 01, year 00, and control 0x90.
- R12: Read data is registered and shows the addressed register as it stood before the edge that samples the address. Addresses outside the top eight read 0xFF, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse, once per second |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |

## Verification
The assertions take the strobe, the tick and the address to be known after reset. They also assume the host writes only through the port, so the seconds, hours and month fields can never be loaded with an illegal code. A date written beyond the current month's length is legal and is not asserted against, because the next day simply wraps it to 01. The stimulus keeps all inputs at defined values. It mixes valid BCD values with arbitrary bytes, so that the acceptance checks of R2, R5 and R7 see both outcomes. Directed sequences place the clock at the day, month and year boundaries before ticking it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NREG  = 8;
  localparam int OFF_W = $clog2(NREG);

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] wday;
    logic [7:0] date;
    logic [7:0] mon;
    logic [7:0] year;
  } rtc_time_t;

  // both digits decimal and lo <= v <= hi (bounds given in BCD)
  function automatic logic bcd_ok(input logic [7:0] v, input logic [7:0] lo,
                                  input logic [7:0] hi);
    return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9) && (v >= lo) && (v <= hi);
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  // divisible by 4: even tens with units 0/4/8, odd tens with units 2/6
  function automatic logic bcd_leap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return bcd_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_wr_decode.sv
module rtc_wr_decode
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output logic              in_win,
  output logic [NREG-1:0]   wr_sel
);
  assign in_win = &addr[ADDR_W-1:OFF_W];

  for (genvar i = 0; i < NREG; i++) begin : g_sel
    assign wr_sel[i] = wr_en && in_win && (addr[OFF_W-1:0] == OFF_W'(i));
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [NREG-1:0] wr_sel,
  input  logic [7:0]      wr_data,
  output rtc_time_t       time_q,
  output logic            stop_q,
  output logic            cent_q,
  output logic [7:0]      ctrl_q
);
  rtc_time_t adv, nxt;
  logic      stop_n, cent_n;
  logic [7:0] ctrl_n;
  logic c_sec, c_min, c_day, c_mon;

  // tick carry chain, from the pre-write state
  always_comb begin
    adv   = time_q;
    c_sec = 1'b0;
    c_min = 1'b0;
    c_day = 1'b0;
    c_mon = 1'b0;
    if (tick && !stop_q) begin
      c_sec   = (time_q.sec == 8'h59);
      adv.sec = c_sec ? 8'h00 : bcd_inc(time_q.sec);
      if (c_sec) begin
        c_min   = (time_q.min == 8'h59);
        adv.min = c_min ? 8'h00 : bcd_inc(time_q.min);
      end
      if (c_min) begin
        c_day    = (time_q.hour == 8'h23);
        adv.hour = c_day ? 8'h00 : bcd_inc(time_q.hour);
      end
      if (c_day) begin
        adv.wday = (time_q.wday[2:0] == 3'd7) ? 8'd1 : time_q.wday + 8'd1;
        c_mon    = (time_q.date >= month_len(time_q.mon, time_q.year));
        adv.date = c_mon ? 8'h01 : bcd_inc(time_q.date);
      end
      if (c_mon) begin
        adv.mon = (time_q.mon == 8'h12) ? 8'h01 : bcd_inc(time_q.mon);
        if (time_q.mon == 8'h12)
          adv.year = (time_q.year == 8'h99) ? 8'h00 : bcd_inc(time_q.year);
      end
    end
  end

  // accepted writes override the ticked value of their own field
  always_comb begin
    nxt    = adv;
    stop_n = stop_q;
    cent_n = cent_q;
    ctrl_n = ctrl_q;
    if (wr_sel[0]) ctrl_n = (wr_data & 8'hDF) | 8'h90;
    if (wr_sel[1]) begin
      stop_n = wr_data[7];
      if (bcd_ok({1'b0, wr_data[6:0]}, 8'h00, 8'h59)) nxt.sec = {1'b0, wr_data[6:0]};
    end
    if (wr_sel[2] && bcd_ok({1'b0, wr_data[6:0]}, 8'h00, 8'h59)) nxt.min = {1'b0, wr_data[6:0]};
    if (wr_sel[3] && bcd_ok({2'b0, wr_data[5:0]}, 8'h00, 8'h23)) nxt.hour = {2'b0, wr_data[5:0]};
    if (wr_sel[4]) begin
      nxt.wday = {5'b0, wr_data[2:0]};
      cent_n   = wr_data[6];
    end
    if (wr_sel[5] && bcd_ok({2'b0, wr_data[5:0]}, 8'h01, 8'h31)) nxt.date = {2'b0, wr_data[5:0]};
    if (wr_sel[6] && bcd_ok({3'b0, wr_data[4:0]}, 8'h01, 8'h12)) nxt.mon = {3'b0, wr_data[4:0]};
    if (wr_sel[7] && bcd_ok(wr_data, 8'h00, 8'h99)) nxt.year = wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      time_q <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 8'h01,
                  date: 8'h01, mon: 8'h01, year: 8'h00};
      stop_q <= 1'b0;
      cent_q <= 1'b0;
      ctrl_q <= 8'h90;
    end else begin
      time_q <= nxt;
      stop_q <= stop_n;
      cent_q <= cent_n;
      ctrl_q <= ctrl_n;
    end
  end
endmodule

// File: rtl/rtc_read_mux.sv
module rtc_read_mux
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_win,
  input  logic [OFF_W-1:0] offs,
  input  rtc_time_t        time_q,
  input  logic             stop_q,
  input  logic             cent_q,
  input  logic [7:0]       ctrl_q,
  output logic [7:0]       rd_data
);
  logic [7:0] view [NREG];

  assign view[0] = ctrl_q;
  assign view[1] = {stop_q, time_q.sec[6:0]};
  assign view[2] = time_q.min;
  assign view[3] = time_q.hour;
  assign view[4] = time_q.wday | {1'b0, cent_q, 6'b0};
  assign view[5] = time_q.date;
  assign view[6] = time_q.mon;
  assign view[7] = time_q.year;

  always_ff @(posedge clk) begin
    if (rst)          rd_data <= 8'hFF;
    else if (!in_win) rd_data <= 8'hFF;
    else              rd_data <= view[offs];
  end
endmodule

// File: rtl/bcd_rtc_bank.sv
module bcd_rtc_bank
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data
);
  logic            in_win;
  logic [NREG-1:0] wr_sel;
  rtc_time_t       cal_time;
  logic            cal_stop, cal_cent;
  logic [7:0]      cal_ctrl;

  rtc_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .wr_en(wr_en), .in_win(in_win), .wr_sel(wr_sel)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst(rst), .tick(tick), .wr_sel(wr_sel), .wr_data(wr_data),
    .time_q(cal_time), .stop_q(cal_stop), .cent_q(cal_cent), .ctrl_q(cal_ctrl)
  );

  rtc_read_mux u_rd (
    .clk(clk), .rst(rst), .in_win(in_win), .offs(addr[OFF_W-1:0]),
    .time_q(cal_time), .stop_q(cal_stop), .cent_q(cal_cent), .ctrl_q(cal_ctrl),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/rtc_bank_checker.sv
module rtc_bank_checker
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [7:0]        rd_data,
  input rtc_time_t         t_now,
  input logic              stopped
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = {ADDR_W{1'b1}} << OFF_W;

  p_ctrl_forced_r3: assert property (@(posedge clk) disable iff (rst)
    (addr == CTRL_ADDR) |=> (rd_data[7] && rd_data[4] && !rd_data[5]));

  p_sec_legal_r2: assert property (@(posedge clk) disable iff (rst)
    (t_now.sec[3:0] <= 4'd9) && (t_now.sec <= 8'h59));

  p_hour_legal_r5: assert property (@(posedge clk) disable iff (rst)
    (t_now.hour[3:0] <= 4'd9) && (t_now.hour <= 8'h23));

  p_month_legal_r7: assert property (@(posedge clk) disable iff (rst)
    (t_now.mon[3:0] <= 4'd9) && (t_now.mon >= 8'h01) && (t_now.mon <= 8'h12));

  p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    (stopped && !wr_en) |=> $stable(t_now));

  p_tick_moves_r8: assert property (@(posedge clk) disable iff (rst)
    (tick && !stopped && !wr_en) |=> (t_now.sec != $past(t_now.sec)));

  p_unmapped_r12: assert property (@(posedge clk) disable iff (rst)
    !(&addr[ADDR_W-1:OFF_W]) |=> (rd_data == 8'hFF));
endmodule

bind bcd_rtc_bank rtc_bank_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .addr(addr), .wr_en(wr_en),
  .rd_data(rd_data), .t_now(cal_time), .stopped(cal_stop)
);

// File: tb/bcd_rtc_bank_test.sv
module bcd_rtc_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [12:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // behavioural model, plain integers
  int m_s, m_mi, m_h, m_wd, m_dt, m_mo, m_yr, m_stp, m_cen, m_ctl;
  int exp_rd = 8'hFF;
  string exp_tag = "R12";
  string cur_tag = "";

  bcd_rtc_bank uut (.clk(clk), .rst(rst), .tick(tick), .addr(addr),
                    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data));

  always #4 clk = ~clk;

  function automatic int to_bcd(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int from_bcd(int b);
    int hi = (b >> 4) & 15;
    int lo = b & 15;
    if (hi > 9 || lo > 9) return -1;
    return hi * 10 + lo;
  endfunction

  function automatic int mdays(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int model_read(int a);
    if ((a >> 3) != 13'h1FFF >> 3) return 8'hFF;
    case (a & 7)
      0: return m_ctl;
      1: return (m_stp << 7) | to_bcd(m_s);
      2: return to_bcd(m_mi);
      3: return to_bcd(m_h);
      4: return (m_cen << 6) | m_wd;
      5: return to_bcd(m_dt);
      6: return to_bcd(m_mo);
      default: return to_bcd(m_yr);
    endcase
  endfunction

  function automatic string tag_of(int a);
    if (cur_tag != "") return cur_tag;
    if ((a >> 3) != 13'h1FFF >> 3) return "R12";
    case (a & 7)
      0: return "R3";
      1: return "R2";
      2, 3: return "R5";
      4: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic model_reset();
    m_s = 0; m_mi = 0; m_h = 0; m_wd = 1; m_dt = 1; m_mo = 1; m_yr = 0;
    m_stp = 0; m_cen = 0; m_ctl = 8'h90;
  endtask

  task automatic model_step(int a, bit we, int d, bit tk);
    int s = m_s, mi = m_mi, h = m_h, wd = m_wd, dt = m_dt, mo = m_mo, yr = m_yr;
    int v;
    if (tk && m_stp == 0) begin
      if (m_s != 59) s = m_s + 1;
      else begin
        s = 0;
        if (m_mi != 59) mi = m_mi + 1;
        else begin
          mi = 0;
          if (m_h != 23) h = m_h + 1;
          else begin
            h = 0;
            wd = (m_wd >= 7) ? 1 : m_wd + 1;
            if (m_dt < mdays(m_mo, m_yr)) dt = m_dt + 1;
            else begin
              dt = 1;
              if (m_mo != 12) mo = m_mo + 1;
              else begin
                mo = 1;
                yr = (m_yr == 99) ? 0 : m_yr + 1;
              end
            end
          end
        end
      end
    end
    if (we && (a >> 3) == 13'h1FFF >> 3) begin
      case (a & 7)
        0: m_ctl = ((d & 8'hDF) | 8'h90) & 8'hFF;
        1: begin
          v = from_bcd(d & 8'h7F);
          if (v >= 0 && v <= 59) s = v;
          m_stp = (d >> 7) & 1;
        end
        2: begin v = from_bcd(d & 8'h7F); if (v >= 0 && v <= 59) mi = v; end
        3: begin v = from_bcd(d & 8'h3F); if (v >= 0 && v <= 23) h = v; end
        4: begin wd = d & 7; m_cen = (d >> 6) & 1; end
        5: begin v = from_bcd(d & 8'h3F); if (v >= 1 && v <= 31) dt = v; end
        6: begin v = from_bcd(d & 8'h1F); if (v >= 1 && v <= 12) mo = v; end
        default: begin v = from_bcd(d); if (v >= 0 && v <= 99) yr = v; end
      endcase
    end
    m_s = s; m_mi = mi; m_h = h; m_wd = wd; m_dt = dt; m_mo = mo; m_yr = yr;
  endtask

  // entered and left at a falling edge
  task automatic step(int a, bit we, int d, bit tk);
    vectors++;
    if (rd_data !== exp_rd[7:0]) begin
      miscompares++;
      $display("FAIL %s rd_data got %02h exp %02h", exp_tag, rd_data, exp_rd[7:0]);
    end
    addr = a[12:0]; wr_en = we; wr_data = d[7:0]; tick = tk;
    exp_rd = model_read(a);
    exp_tag = tag_of(a);
    model_step(a, we, d, tk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(int off, int d);
    step(13'h1FF8 + off, 1'b1, d, 1'b0);
  endtask

  task automatic read_all();
    for (int i = 0; i < 8; i++) step(13'h1FF8 + i, 1'b0, 0, 1'b0);
  endtask

  task automatic set_time(int yr, int mo, int dt, int h, int mi, int s);
    wr(7, yr); wr(6, mo); wr(5, dt); wr(3, h); wr(2, mi); wr(1, s);
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    cur_tag = "R11";
    read_all();

    cur_tag = "R8";
    wr(4, 8'h07);
    set_time(8'h10, 8'h05, 8'h10, 8'h23, 8'h59, 8'h59);
    step(13'h1FF9, 1'b0, 0, 1'b1);
    read_all();
    step(13'h1FF9, 1'b0, 0, 1'b1);
    step(13'h1FF9, 1'b0, 0, 1'b1);
    read_all();

    cur_tag = "R9";
    set_time(8'h04, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    step(13'h1FFD, 1'b0, 0, 1'b1); read_all();
    set_time(8'h04, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59);
    step(13'h1FFD, 1'b0, 0, 1'b1); read_all();
    set_time(8'h03, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    step(13'h1FFD, 1'b0, 0, 1'b1); read_all();
    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    step(13'h1FFD, 1'b0, 0, 1'b1); read_all();
    set_time(8'h21, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
    step(13'h1FFD, 1'b0, 0, 1'b1); read_all();

    cur_tag = "R4";
    wr(1, 8'h90);
    for (int i = 0; i < 5; i++) step(13'h1FF9, 1'b0, 0, 1'b1);
    read_all();
    wr(1, 8'h7F);
    step(13'h1FF9, 1'b0, 0, 1'b1);
    step(13'h1FF9, 1'b0, 0, 1'b1);
    step(13'h1FF9, 1'b0, 0, 1'b0);

    cur_tag = "R10";
    set_time(8'h20, 8'h06, 8'h15, 8'h08, 8'h14, 8'h59);
    step(13'h1FF9, 1'b1, 8'h30, 1'b1);
    read_all();
    step(13'h1FFA, 1'b1, 8'h40, 1'b1);
    read_all();

    cur_tag = "R12";
    step(13'h0123, 1'b1, 8'h55, 1'b0);
    step(13'h1FF7, 1'b1, 8'h00, 1'b0);
    step(13'h0000, 1'b0, 0, 1'b0);
    read_all();

    cur_tag = "R3";
    wr(0, 8'h2F); step(13'h1FF8, 1'b0, 0, 1'b0);
    wr(0, 8'h00); step(13'h1FF8, 1'b0, 0, 1'b0);

    cur_tag = "R6";
    wr(4, 8'hC5); step(13'h1FFC, 1'b0, 0, 1'b0);
    wr(4, 8'h03); step(13'h1FFC, 1'b0, 0, 1'b0);

    cur_tag = "R1";
    read_all();

    cur_tag = "";
    for (int n = 0; n < 6000; n++) begin
      int a, d;
      bit we, tk;
      a  = ($urandom % 10 < 8) ? 13'h1FF8 + ($urandom % 8) : ($urandom % 13'h1FF8);
      we = ($urandom % 10) < 3;
      d  = ($urandom % 2) ? to_bcd($urandom % 100) : ($urandom % 256);
      if ((a & 7) == 1 && ($urandom % 4) != 0) d = d & 8'h7F;
      tk = ($urandom % 10) < 4;
      step(a, we, d, tk);
    end
    step(13'h0000, 1'b0, 0, 1'b0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog expired got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule